// File: doc/BRIEF.md
# Event-Set Read-Clear Status Register Bank

This block gathers "new value available" indications from internal producers. Each producer drives one event line. A rising edge on that line sets a sticky flag. The flags are grouped eight to a byte, and a bus master reads them through a simple read port. A read returns the byte as it stood before the access. The flags that read back as 1 are then cleared automatically, so each flag reports whether fresh data has arrived since the previous read.

The same register space holds a power-on indicator. Hardware reset sets it. Reads leave it alone, and only an explicit cancel write from software clears it. Software uses it to tell a start after power loss (program everything) from normal operation (program only what changed). Event lines are assumed to be synchronous to the block clock already.

Top module: `evt_status_bank`

## Requirements
- R1: While `rst_n` is low and after its release, every event flag is 0, the power-on flag is 1 and `rd_data` is 0.
- R2: A rising edge on `evt_i[i]` sets flag i at the next clock edge. The previous event value resets to 0, so an event line already high when reset is released also sets its flag.
- R3: An event line held high sets its flag only once; after the flag is read and cleared it stays 0 until the line falls and rises again.
- R4: A read strobe with `rd_addr` = b for b below `BYTES` loads `rd_data` at the same edge with flags 8b+7..8b, flag 8b+j on bit j, taken before any clear.
- R5: That read clears the addressed byte's flags, visible from the cycle after the strobe; flags in other bytes are unaffected.
- R6: If a flag's rising edge falls in the same cycle as a read of its byte, the flag stays 1 afterwards and the read returns the flag's earlier value.
- R7: A read at `rd_addr` = `PWR_ADDR` (default 2) returns the power-on flag on bit 0 and 0 on bits 7..1, and never clears it.
- R8: A write strobe with `wr_addr` = `PWR_ADDR` and `wr_data` bit 0 = 1 clears the power-on flag; writes with bit 0 = 0 or to any other address change nothing, and only reset sets the flag again.
- R9: A read at an address that maps to nothing returns 0 and clears no flag.
- R10: `rd_data` changes only on a read strobe and holds its value in cycles without one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low reset from the external reset pin |
| evt_i | input | 8*BYTES | Event lines, one per flag, synchronous to clk |
| rd_en | input | 1 | Read strobe, one cycle per access |
| rd_addr | input | ADDR_W | Read byte address |
| rd_data | output | 8 | Read data, registered at the edge that takes the strobe |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | ADDR_W | Write byte address |
| wr_data | input | 8 | Write data; bit 0 is the cancel bit |

## Verification
The two functions that can fall in the same cycle are the automatic clear caused by a read and the set caused by an event edge on a flag in the byte being read. The bench raises an event line at the same falling edge where it raises the read strobe, so that both are taken at one clock edge. It does this for a flag that was already 1 and for one that was 0. The result is judged by the value the read returned, which must be the earlier state, and by a second read, which must show both flags set.

// File: rtl/evt_status_bank.sv
module evt_status_bank #(
  parameter int BYTES    = 2,
  parameter int ADDR_W   = 4,
  parameter int PWR_ADDR = BYTES
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [8*BYTES-1:0]   evt_i,
  input  logic                 rd_en,
  input  logic [ADDR_W-1:0]    rd_addr,
  output logic [7:0]           rd_data,
  input  logic                 wr_en,
  input  logic [ADDR_W-1:0]    wr_addr,
  input  logic [7:0]           wr_data
);
  localparam int NF = 8 * BYTES;

  logic [NF-1:0] evt_q, flags_q, rise, rd_mask;
  logic          por_q, cancel;
  logic [7:0]    rd_byte;

  assign rise   = evt_i & ~evt_q;
  assign cancel = wr_en && (wr_addr == ADDR_W'(PWR_ADDR)) && wr_data[0];

  for (genvar b = 0; b < BYTES; b++) begin : g_mask
    assign rd_mask[b*8 +: 8] = {8{rd_en && (rd_addr == ADDR_W'(b))}};
  end

  always_comb begin
    rd_byte = '0;
    for (int b = 0; b < BYTES; b++)
      if (rd_addr == ADDR_W'(b)) rd_byte = flags_q[b*8 +: 8];
    if (rd_addr == ADDR_W'(PWR_ADDR)) rd_byte = {7'b0, por_q};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      evt_q   <= '0;
      flags_q <= '0;
      por_q   <= 1'b1;
      rd_data <= '0;
    end else begin
      evt_q   <= evt_i;
      flags_q <= (flags_q & ~(rd_mask & flags_q)) | rise;
      if (cancel) por_q <= 1'b0;
      if (rd_en) rd_data <= rd_byte;
    end
  end
endmodule

// File: rtl/evt_status_bank_chk.sv
module evt_status_bank_chk #(
  parameter int BYTES    = 2,
  parameter int ADDR_W   = 4,
  parameter int PWR_ADDR = BYTES
) (
  input logic               clk,
  input logic               rst_n,
  input logic [8*BYTES-1:0] evt_i,
  input logic               rd_en,
  input logic [ADDR_W-1:0]  rd_addr,
  input logic [7:0]         rd_data,
  input logic               wr_en,
  input logic [ADDR_W-1:0]  wr_addr,
  input logic [7:0]         wr_data,
  input logic [8*BYTES-1:0] flags_q,
  input logic [8*BYTES-1:0] evt_q,
  input logic               por_q
);
  localparam int NF = 8 * BYTES;

  logic [NF-1:0] edg, sel;
  logic [7:0]    sel_byte;
  logic          in_rng, do_cancel;

  assign edg       = evt_i & ~evt_q;
  assign in_rng    = rd_en && (rd_addr < ADDR_W'(BYTES));
  assign do_cancel = wr_en && (wr_addr == ADDR_W'(PWR_ADDR)) && wr_data[0];

  always_comb begin
    sel      = '0;
    sel_byte = '0;
    for (int b = 0; b < BYTES; b++)
      if (rd_en && rd_addr == ADDR_W'(b)) begin
        sel[b*8 +: 8] = 8'hFF;
        sel_byte      = flags_q[b*8 +: 8];
      end
  end

  AST_EDGE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (|edg) |=> ((flags_q & $past(edg)) == $past(edg)));  // R2

  AST_NO_SPURIOUS_SET: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((flags_q & ~$past(flags_q) & ~$past(edg)) == '0));  // R3

  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    in_rng |=> ((flags_q & $past(sel & ~edg)) == '0));  // R5

  AST_READ_OLD_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    in_rng |=> (rd_data == $past(sel_byte)));  // R4

  AST_PWR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (por_q && !do_cancel) |=> por_q);  // R7

  AST_PWR_CANCEL: assert property (@(posedge clk) disable iff (!rst_n)
    do_cancel |=> !por_q);  // R8

  AST_PWR_NO_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    !por_q |=> !por_q);  // R8

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_data));  // R10
endmodule

bind evt_status_bank evt_status_bank_chk #(
  .BYTES(BYTES), .ADDR_W(ADDR_W), .PWR_ADDR(PWR_ADDR)
) u_chk (
  .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .rd_en(rd_en), .rd_addr(rd_addr),
  .rd_data(rd_data), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .flags_q(flags_q), .evt_q(evt_q), .por_q(por_q)
);

// File: tb/evt_status_bank_bench.sv
module evt_status_bank_bench;
  localparam int BYTES = 2;
  localparam int AW    = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [8*BYTES-1:0] evt = '0;
  logic rd_en = 1'b0, wr_en = 1'b0;
  logic [AW-1:0] rd_addr = '0, wr_addr = '0;
  logic [7:0] rd_data, wr_data = '0;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  evt_status_bank #(.BYTES(BYTES), .ADDR_W(AW), .PWR_ADDR(BYTES)) u_evt_status_bank (
    .clk(clk), .rst_n(rst_n), .evt_i(evt), .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_data(rd_data), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data));

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic do_read(input logic [AW-1:0] a, output logic [7:0] d);
    @(negedge clk); rd_en = 1'b1; rd_addr = a;
    @(negedge clk); rd_en = 1'b0; d = rd_data;
  endtask

  task automatic do_write(input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic pulse(input int i);
    @(negedge clk); evt[i] = 1'b1;
    @(negedge clk); evt[i] = 1'b0;
  endtask

  task automatic apply_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    check("R1 rd_data in reset", rd_data, 8'h00);
    @(negedge clk); rst_n = 1'b1;
    check("R1 rd_data after reset", rd_data, 8'h00);
    do_read(0, d); check("R1 byte0", d, 8'h00);
    do_read(1, d); check("R1 byte1", d, 8'h00);
    do_read(2, d); check("R1 power-on flag", d, 8'h01);
  endtask

  task automatic t_set_clear();
    logic [7:0] d;
    pulse(3); pulse(9); pulse(15);
    do_read(0, d); check("R4 byte0 value", d, 8'h08);
    do_read(0, d); check("R5 byte0 cleared", d, 8'h00);
    do_read(1, d); check("R5 byte1 untouched, R4 bit map", d, 8'h82);
    do_read(1, d); check("R5 byte1 cleared", d, 8'h00);
  endtask

  task automatic t_held();
    logic [7:0] d;
    @(negedge clk); evt[0] = 1'b1;
    do_read(0, d); check("R2 held line sets", d, 8'h01);
    repeat (3) @(negedge clk);
    do_read(0, d); check("R3 held line no re-set", d, 8'h00);
    @(negedge clk); evt[0] = 1'b0;
    pulse(0);
    do_read(0, d); check("R2 new edge sets again", d, 8'h01);
  endtask

  task automatic t_collide();
    logic [7:0] d;
    pulse(1);
    @(negedge clk); rd_en = 1'b1; rd_addr = 0; evt[1] = 1'b1; evt[2] = 1'b1;
    @(negedge clk); rd_en = 1'b0; evt[1] = 1'b0; evt[2] = 1'b0; d = rd_data;
    check("R6 read returns earlier value", d, 8'h02);
    do_read(0, d); check("R6 set wins over clear", d, 8'h06);
    do_read(0, d); check("R5 cleared after collision", d, 8'h00);
  endtask

  task automatic t_unmapped();
    logic [7:0] d;
    pulse(4);
    do_read(7, d); check("R9 unmapped reads 0", d, 8'h00);
    do_read(0, d); check("R9 no clear from unmapped", d, 8'h10);
  endtask

  task automatic t_hold();
    logic [7:0] d;
    pulse(6);
    do_read(0, d);
    repeat (4) @(negedge clk);
    check("R10 rd_data held", rd_data, 8'h40);
  endtask

  task automatic t_power();
    logic [7:0] d;
    do_read(2, d); check("R7 first read", d, 8'h01);
    do_read(2, d); check("R7 read does not clear", d, 8'h01);
    do_write(2, 8'hFE);
    do_read(2, d); check("R8 bit0=0 no cancel", d, 8'h01);
    do_write(5, 8'h01);
    do_read(2, d); check("R8 other address no cancel", d, 8'h01);
    do_write(2, 8'h01);
    do_read(2, d); check("R8 cancel clears", d, 8'h00);
    do_write(2, 8'h00);
    do_read(2, d); check("R8 stays cleared", d, 8'h00);
  endtask

  task automatic t_rereset();
    logic [7:0] d;
    @(negedge clk); rst_n = 1'b0; evt[5] = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 rd_data during reset", rd_data, 8'h00);
    rst_n = 1'b1;
    do_read(2, d); check("R1 power-on set by reset", d, 8'h01);
    do_read(0, d); check("R2 line high at reset release", d, 8'h20);
    @(negedge clk); evt[5] = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_set_clear();
    t_held();
    t_collide();
    t_unmapped();
    t_hold();
    t_power();
    t_rereset();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule